// File: doc/BRIEF.md
# Dual-Set GPIO Blink Generator

This block makes 32 GPIO lines blink from two shared timing generators. Each generator (set A and set B) owns an on-duration and an off-duration, both counted in core clock cycles, and runs a two-state machine that holds its waveform high for the on-duration and low for the off-duration, over and over. A per-line select bit decides which generator a line follows.

A line is actively blinking only when its blink enable bit is set and it is configured as an output. For such a line the pad value is the selected generator's waveform. For any other line it is the static output bit. The durations are loaded through a small write port. Each set has its own 8-byte window: address bit 3 picks the set, and bit 2 picks the on or off register. The per-line controls (blink enable, counter select, output enable, static value) come from the surrounding GPIO register file as plain inputs.

Each generator has two states. `PH_ON` drives the waveform high. `PH_OFF` drives it low. The transition `ON_EXPIRE` (from `PH_ON` to `PH_OFF`) fires when the phase counter has covered the latched on-duration. The transition `OFF_EXPIRE` (from `PH_OFF` to `PH_ON`) fires when it has covered the latched off-duration. Each transition clears the counter and latches the length of the next phase from the live register.

Top module: `gpio_blink_gen`

## Requirements
- R1: On reset, both generators enter `PH_ON` with the counter cleared, and all four duration registers read as 1. A blinking line is therefore high in the first cycle after reset and low in the second.
- R2: A write with `wr_en` high loads `wr_data` into one duration register. `wr_addr[3]` selects the set (0 = A, 1 = B), `wr_addr[2]` selects the register (0 = on, 1 = off), and `wr_addr[1:0]` is ignored. A write to one register leaves the other three unchanged.
- R3: Once settled, a generator's waveform is high for exactly the on-duration in cycles, then low for exactly the off-duration, and repeats.
- R4: A duration register holding 0 acts as a duration of 1 cycle.
- R5: A duration written while its phase is running does not change that phase. The new value applies from the next time that phase starts.
- R6: A line whose `cnt_sel` bit is 0 follows set A. A line whose bit is 1 follows set B.
- R7: When `blink_en[i]` and `line_oe[i]` are both 1, `act_o[i]` is 1 and `pin_o[i]` is the selected waveform. Otherwise `act_o[i]` is 0 and `pin_o[i]` equals `out_val[i]`. While a line blinks, its `out_val` bit has no effect.
- R8: `wave_o[i]` carries the selected waveform for active lines and is 0 for inactive lines.
- R9: The two sets run independently. Reprogramming one set does not change the timing of the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock; durations count its cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Duration register write strobe |
| wr_addr | input | 4 | Byte address: bit 3 set, bit 2 on/off |
| wr_data | input | 32 | Duration value to write |
| blink_en | input | 32 | Per-line blink enable |
| cnt_sel | input | 32 | Per-line set select (0 = A, 1 = B) |
| line_oe | input | 32 | Per-line output enable (1 = output) |
| out_val | input | 32 | Per-line static output value |
| wave_o | output | 32 | Selected waveform, masked by line activity |
| act_o | output | 32 | Per-line blink-active flag for the pad mux |
| pin_o | output | 32 | Resulting pad output value |

## Verification
The assertions assume that the per-line control inputs change only between clock edges and that the durations written are at least 1. The checks on the pad mux are combinational, so any stable input combination satisfies them. The stimulus changes its inputs only on falling edges. It writes a duration of 0 only in the single case that tests the clamp, and the run-length measurements taken in that window account for the clamp.

// File: rtl/gpio_blink_pkg.sv
package gpio_blink_pkg;
    localparam int NUM_SETS  = 2;
    localparam int SET_LSB   = 3;
    localparam int SEL_BIT   = 2;
    localparam int DUR_RESET = 1;

    typedef enum logic {
        PH_ON  = 1'b0,
        PH_OFF = 1'b1
    } blink_phase_e;
endpackage

// File: rtl/blink_dur_regs.sv
module blink_dur_regs
    import gpio_blink_pkg::*;
#(
    parameter int DUR_W  = 32,
    parameter int ADDR_W = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [ADDR_W-1:0]                  wr_addr,
    input  logic [DUR_W-1:0]                   wr_data,
    output logic [NUM_SETS-1:0][DUR_W-1:0]     on_dur,
    output logic [NUM_SETS-1:0][DUR_W-1:0]     off_dur
);
    localparam logic [DUR_W-1:0] RST_VAL = DUR_W'(DUR_RESET);

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        logic hit;
        assign hit = wr_en && (wr_addr[SET_LSB] == 1'(s));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                on_dur[s]  <= RST_VAL;
                off_dur[s] <= RST_VAL;
            end else if (hit) begin
                if (wr_addr[SEL_BIT]) off_dur[s] <= wr_data;
                else                  on_dur[s]  <= wr_data;
            end
        end
    end
endmodule

// File: rtl/blink_phase_gen.sv
module blink_phase_gen
    import gpio_blink_pkg::*;
#(
    parameter int DUR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DUR_W-1:0] on_dur,
    input  logic [DUR_W-1:0] off_dur,
    output logic             wave_o
);
    localparam logic [DUR_W-1:0] ONE = DUR_W'(1);

    blink_phase_e     state_q, state_d;
    logic [DUR_W-1:0] cnt_q, cnt_d;
    logic [DUR_W-1:0] len_q, len_d;
    logic             expire;

    function automatic logic [DUR_W-1:0] clamp(input logic [DUR_W-1:0] v);
        return (v == '0) ? ONE : v;
    endfunction

    // next state: ON_EXPIRE and OFF_EXPIRE
    always_comb begin
        expire  = (cnt_q >= (len_q - ONE));
        state_d = state_q;
        cnt_d   = cnt_q + ONE;
        len_d   = len_q;
        unique case (state_q)
            PH_ON: begin
                if (expire) begin
                    state_d = PH_OFF;
                    cnt_d   = '0;
                    len_d   = clamp(off_dur);
                end
            end
            PH_OFF: begin
                if (expire) begin
                    state_d = PH_ON;
                    cnt_d   = '0;
                    len_d   = clamp(on_dur);
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_ON;
            cnt_q   <= '0;
            len_q   <= clamp(DUR_W'(DUR_RESET));
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            len_q   <= len_d;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            PH_ON:  wave_o = 1'b1;
            PH_OFF: wave_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/blink_line_mux.sv
module blink_line_mux
    import gpio_blink_pkg::*;
#(
    parameter int LINES = 32
) (
    input  logic [NUM_SETS-1:0] set_wave,
    input  logic [LINES-1:0]    blink_en,
    input  logic [LINES-1:0]    cnt_sel,
    input  logic [LINES-1:0]    line_oe,
    input  logic [LINES-1:0]    out_val,
    output logic [LINES-1:0]    wave_o,
    output logic [LINES-1:0]    act_o,
    output logic [LINES-1:0]    pin_o
);
    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic sel_wave;
        assign sel_wave  = set_wave[cnt_sel[i]];
        assign act_o[i]  = blink_en[i] & line_oe[i];
        assign wave_o[i] = act_o[i] & sel_wave;
        assign pin_o[i]  = act_o[i] ? sel_wave : out_val[i];
    end
endmodule

// File: rtl/gpio_blink_gen.sv
module gpio_blink_gen
    import gpio_blink_pkg::*;
#(
    parameter int LINES  = 32,
    parameter int DUR_W  = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DUR_W-1:0]  wr_data,
    input  logic [LINES-1:0]  blink_en,
    input  logic [LINES-1:0]  cnt_sel,
    input  logic [LINES-1:0]  line_oe,
    input  logic [LINES-1:0]  out_val,
    output logic [LINES-1:0]  wave_o,
    output logic [LINES-1:0]  act_o,
    output logic [LINES-1:0]  pin_o
);
    logic [NUM_SETS-1:0][DUR_W-1:0] on_dur;
    logic [NUM_SETS-1:0][DUR_W-1:0] off_dur;
    logic [NUM_SETS-1:0]            set_wave;

    blink_dur_regs #(.DUR_W(DUR_W), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .on_dur  (on_dur),
        .off_dur (off_dur)
    );

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_gen
        blink_phase_gen #(.DUR_W(DUR_W)) u_gen (
            .clk     (clk),
            .rst_n   (rst_n),
            .on_dur  (on_dur[s]),
            .off_dur (off_dur[s]),
            .wave_o  (set_wave[s])
        );
    end

    blink_line_mux #(.LINES(LINES)) u_mux (
        .set_wave (set_wave),
        .blink_en (blink_en),
        .cnt_sel  (cnt_sel),
        .line_oe  (line_oe),
        .out_val  (out_val),
        .wave_o   (wave_o),
        .act_o    (act_o),
        .pin_o    (pin_o)
    );
endmodule

// File: rtl/gpio_blink_chk.sv
module gpio_blink_chk #(
    parameter int LINES = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LINES-1:0] blink_en,
    input logic [LINES-1:0] cnt_sel,
    input logic [LINES-1:0] line_oe,
    input logic [LINES-1:0] out_val,
    input logic [LINES-1:0] wave_o,
    input logic [LINES-1:0] act_o,
    input logic [LINES-1:0] pin_o,
    input logic [1:0]       set_wave
);
    logic [LINES-1:0] want_act;
    assign want_act = blink_en & line_oe;

    AST_IDLE_STATIC: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_o ^ out_val) & ~want_act) == '0); // R7
    AST_ACTIVE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_o ^ wave_o) & want_act) == '0 && act_o == want_act); // R7
    AST_WAVE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wave_o & ~want_act) == '0); // R8
    AST_STEER_A: assert property (@(posedge clk) disable iff (!rst_n)
        (wave_o & want_act & ~cnt_sel) == ({LINES{set_wave[0]}} & want_act & ~cnt_sel)); // R6
    AST_STEER_B: assert property (@(posedge clk) disable iff (!rst_n)
        (wave_o & want_act & cnt_sel) == ({LINES{set_wave[1]}} & want_act & cnt_sel)); // R6
endmodule

bind gpio_blink_gen gpio_blink_chk #(.LINES(LINES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .blink_en (blink_en),
    .cnt_sel  (cnt_sel),
    .line_oe  (line_oe),
    .out_val  (out_val),
    .wave_o   (wave_o),
    .act_o    (act_o),
    .pin_o    (pin_o),
    .set_wave (set_wave)
);

// File: tb/tb_gpio_blink_gen.sv
module tb_gpio_blink_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] blink_en = '0, cnt_sel = '0, line_oe = '0, out_val = '0;
    logic [31:0] wave_o, act_o, pin_o;

    int vectors = 0;
    int fails = 0;

    typedef struct {
        int    line;
        logic  lvl;
        int    exp;
        string tag;
    } run_item_t;
    run_item_t sb_q[$];

    always #2 clk = ~clk;

    gpio_blink_gen dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .blink_en(blink_en), .cnt_sel(cnt_sel), .line_oe(line_oe), .out_val(out_val),
        .wave_o(wave_o), .act_o(act_o), .pin_o(pin_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_len(input int line, input logic lvl, output int n);
        int guard = 0;
        while (pin_o[line] == lvl && guard < 2000) begin @(negedge clk); guard++; end
        while (pin_o[line] != lvl && guard < 2000) begin @(negedge clk); guard++; end
        n = 0;
        while (pin_o[line] == lvl && guard < 2000) begin n++; @(negedge clk); guard++; end
    endtask

    task automatic expect_run(input int line, input logic lvl, input int exp, input string tag);
        run_item_t it;
        it.line = line; it.lvl = lvl; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic monitor_drain();
        while (sb_q.size() > 0) begin
            run_item_t it;
            int n;
            it = sb_q.pop_front();
            run_len(it.line, it.lvl, n);
            check(it.tag, 32'(n), 32'(it.exp));
        end
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int n;
        // line0: blink, set A; line1: blink, set B; line2: blink but input; line3: output static
        blink_en = 32'h0000_0007;
        cnt_sel  = 32'h0000_0002;
        line_oe  = 32'h0000_000B;
        out_val  = 32'hA5A5_0F0F;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: first cycle after reset high, then low (durations reset to 1)
        check("R1 first cycle high", 32'(pin_o[1:0]), 32'h3);
        @(negedge clk);
        check("R1 second cycle low", 32'(pin_o[1:0]), 32'h0);
        // R7/R8 static lines and masking
        check("R7 act vector", act_o, 32'h0000_0003);
        check("R7 static pins", pin_o & 32'hFFFF_FFFC, out_val & 32'hFFFF_FFFC);
        check("R8 wave masked", wave_o & 32'hFFFF_FFFC, 32'h0);

        // R2: program both sets through their windows (low bits ignored)
        wr(4'h0, 32'd3);
        wr(4'h4, 32'd5);
        wr(4'h9, 32'd7);
        wr(4'hE, 32'd2);
        repeat (20) @(negedge clk);
        expect_run(0, 1'b1, 3, "R3 A on");
        expect_run(0, 1'b0, 5, "R3 A off");
        expect_run(1, 1'b1, 7, "R2 B on via addr 0x9");
        expect_run(1, 1'b0, 2, "R2 B off via addr 0xE");
        monitor_drain();

        // R7: static value ignored while blinking
        out_val[0] = 1'b1;
        expect_run(0, 1'b0, 5, "R7 out_val ignored");
        monitor_drain();
        out_val[0] = 1'b0;

        // R4: zero duration acts as one
        wr(4'h4, 32'd0);
        repeat (12) @(negedge clk);
        expect_run(0, 1'b0, 1, "R4 zero off");
        expect_run(1, 1'b1, 7, "R9 B unaffected");
        monitor_drain();
        wr(4'h4, 32'd5);

        // R5: mid-phase write waits for next phase start
        wr(4'h0, 32'd10);
        wr(4'h4, 32'd10);
        repeat (30) @(negedge clk);
        run_len(0, 1'b0, n);
        while (pin_o[0] == 1'b0) @(negedge clk);
        wr(4'h0, 32'd4);
        n = 1;
        while (pin_o[0] == 1'b1 && n < 100) begin n++; @(negedge clk); end
        check("R5 running phase keeps old length", 32'(n), 32'd10);
        expect_run(0, 1'b1, 4, "R5 new length next phase");
        monitor_drain();

        // R6: steer line0 to set B
        cnt_sel[0] = 1'b1;
        @(negedge clk);
        expect_run(0, 1'b1, 7, "R6 line0 on set B");
        expect_run(0, 1'b0, 2, "R6 line0 off set B");
        monitor_drain();

        // R7: drop output enable on line1
        line_oe[1] = 1'b0;
        out_val[1] = 1'b1;
        @(negedge clk);
        check("R7 inactive line static", 32'(pin_o[1]), 32'h1);
        check("R8 inactive wave zero", 32'(wave_o[1]), 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule